// File: doc/BRIEF.md
# Dual-Master Hardware Semaphore Unit

This block holds a bank of hardware semaphores that two bus masters share: a host processor and a coprocessor core. Each master has a 16-bit register of its own. A write carries a per-semaphore enable in the upper byte and a value per semaphore in the lower byte. In one write a master can try to claim any subset of semaphores and give back any other subset. A read returns only the semaphores that the reading master holds at that moment. The other master's locks read as zero, so a master can tell whether a claim took hold by reading its register back.

Each semaphore is a small state machine with three states: `FREE`, `HOST_HELD` and `COP_HELD`. Its transitions are these:
- `FREE -> HOST_HELD` on a host claim.
- `FREE -> COP_HELD` on a coprocessor claim when the host makes no claim in the same cycle.
- `HOST_HELD -> FREE` on a host release.
- `COP_HELD -> FREE` on a coprocessor release.

Every other request leaves the state as it is. A write is applied on the clock edge that samples its strobe, and the read in the next cycle shows the result.

Top module: `sem_bank`

## Requirements
- R1: After reset every semaphore is free, so both read words are 0x0000.
- R2: Bits 15..8 of both read words always read as zero.
- R3: A write changes semaphore i only when bit 8+i of the written word is 1. Bits with a 0 enable are left untouched.
- R4: A write with bit 8+i = 1 and bit i = 1 claims semaphore i for the writer when the semaphore is free.
- R5: A claim on a semaphore held by the other master fails and leaves the holder unchanged.
- R6: A write with bit 8+i = 1 and bit i = 0 frees semaphore i when the writer holds it.
- R7: A release by the master that does not hold the semaphore has no effect.
- R8: When both masters claim the same free semaphore in the same cycle, the host wins and the coprocessor reads 0 for that bit.
- R9: Bit i of a master's read word is 1 exactly when that master holds semaphore i. No bit is 1 in both read words at once.
- R10: The effect of a write shows in the read words in the cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 16 | Host write word: enables in [15:8], values in [7:0] |
| host_rdata | output | 16 | Semaphores held by the host |
| cop_wr | input | 1 | Coprocessor write strobe |
| cop_wdata | input | 16 | Coprocessor write word: enables in [15:8], values in [7:0] |
| cop_rdata | output | 16 | Semaphores held by the coprocessor |

## Verification
The hardest case to reach from the ports is two masters acting on the same semaphore in the same cycle. That covers both masters claiming a free semaphore, and one master releasing while the other claims. The directed stimulus strobes both write ports in the same cycle with overlapping enables. A random phase then drives both ports with dense, partly overlapping enables, so same-cycle collisions happen often against every kind of holder.

// File: rtl/sem_pkg.sv
package sem_pkg;
    typedef enum logic [1:0] {
        SEM_FREE = 2'd0,
        SEM_HOST = 2'd1,
        SEM_COP  = 2'd2
    } sem_state_t;
endpackage

// File: rtl/sem_req_decode.sv
module sem_req_decode #(
    parameter int N_SEM = 8,
    localparam int WORD_W = 2 * N_SEM
) (
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    output logic [N_SEM-1:0]  claim,
    output logic [N_SEM-1:0]  give
);
    for (genvar i = 0; i < N_SEM; i++) begin : g_bit
        logic en;
        assign en       = wr & wdata[N_SEM + i];
        assign claim[i] = en & wdata[i];
        assign give[i]  = en & ~wdata[i];
    end
endmodule

// File: rtl/sem_cell.sv
module sem_cell
    import sem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic host_claim,
    input  logic host_give,
    input  logic cop_claim,
    input  logic cop_give,
    output logic host_own,
    output logic cop_own
);
    sem_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEM_FREE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEM_FREE: begin
                if (host_claim)     state_d = SEM_HOST;
                else if (cop_claim) state_d = SEM_COP;
            end
            SEM_HOST: if (host_give) state_d = SEM_FREE;
            SEM_COP:  if (cop_give)  state_d = SEM_FREE;
            default:  state_d = SEM_FREE;
        endcase
    end

    always_comb begin
        host_own = 1'b0;
        cop_own  = 1'b0;
        unique case (state_q)
            SEM_HOST: host_own = 1'b1;
            SEM_COP:  cop_own  = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/sem_view.sv
module sem_view #(
    parameter int N_SEM = 8,
    localparam int WORD_W = 2 * N_SEM
) (
    input  logic [N_SEM-1:0]  own,
    output logic [WORD_W-1:0] rdata
);
    assign rdata = {{N_SEM{1'b0}}, own};
endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
    parameter int N_SEM = 8,
    localparam int WORD_W = 2 * N_SEM
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    input  logic              cop_wr,
    input  logic [WORD_W-1:0] cop_wdata,
    output logic [WORD_W-1:0] cop_rdata
);
    logic [N_SEM-1:0] h_claim, h_give, c_claim, c_give;
    logic [N_SEM-1:0] h_own, c_own;

    sem_req_decode #(.N_SEM(N_SEM)) u_host_dec (
        .wr(host_wr), .wdata(host_wdata), .claim(h_claim), .give(h_give)
    );
    sem_req_decode #(.N_SEM(N_SEM)) u_cop_dec (
        .wr(cop_wr), .wdata(cop_wdata), .claim(c_claim), .give(c_give)
    );

    for (genvar i = 0; i < N_SEM; i++) begin : g_cell
        sem_cell u_cell (
            .clk(clk), .rst_n(rst_n),
            .host_claim(h_claim[i]), .host_give(h_give[i]),
            .cop_claim(c_claim[i]),  .cop_give(c_give[i]),
            .host_own(h_own[i]),     .cop_own(c_own[i])
        );
    end

    sem_view #(.N_SEM(N_SEM)) u_host_view (.own(h_own), .rdata(host_rdata));
    sem_view #(.N_SEM(N_SEM)) u_cop_view  (.own(c_own), .rdata(cop_rdata));
endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk #(
    parameter int N_SEM = 8,
    localparam int WORD_W = 2 * N_SEM
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic [WORD_W-1:0] host_wdata,
    input logic [WORD_W-1:0] host_rdata,
    input logic              cop_wr,
    input logic [WORD_W-1:0] cop_wdata,
    input logic [WORD_W-1:0] cop_rdata
);
    logic [N_SEM-1:0] h_en, c_en, freev, contest, h_foreign_rel;
    assign h_en    = host_wr ? host_wdata[WORD_W-1:N_SEM] : '0;
    assign c_en    = cop_wr  ? cop_wdata[WORD_W-1:N_SEM]  : '0;
    assign freev   = ~host_rdata[N_SEM-1:0] & ~cop_rdata[N_SEM-1:0];
    assign contest = freev & h_en & host_wdata[N_SEM-1:0] & c_en & cop_wdata[N_SEM-1:0];
    assign h_foreign_rel = h_en & ~host_wdata[N_SEM-1:0] & cop_rdata[N_SEM-1:0] & ~c_en;

    // R2
    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rdata[WORD_W-1:N_SEM] == '0) && (cop_rdata[WORD_W-1:N_SEM] == '0));

    // R9
    assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rdata[N_SEM-1:0] & cop_rdata[N_SEM-1:0]) == '0);

    // R3
    assert_idle_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_wr && !cop_wr) |=> ($stable(host_rdata) && $stable(cop_rdata)));

    // R8
    assert_host_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|contest) |=> ((host_rdata[N_SEM-1:0] & $past(contest)) == $past(contest)));

    // R7
    assert_foreign_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|h_foreign_rel) |=> ((cop_rdata[N_SEM-1:0] & $past(h_foreign_rel)) == $past(h_foreign_rel)));
endmodule

bind sem_bank sem_bank_chk #(.N_SEM(N_SEM)) u_chk (.*);

// File: tb/sem_bank_bench.sv
module sem_bank_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;
    localparam int W = 2 * N;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_wr = 1'b0, cop_wr = 1'b0;
    logic [W-1:0] host_wdata = '0, cop_wdata = '0;
    logic [W-1:0] host_rdata, cop_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int owner [N];   // 0 free, 1 host, 2 coprocessor
    string tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    sem_bank u_sem_bank (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .cop_wr(cop_wr), .cop_wdata(cop_wdata), .cop_rdata(cop_rdata)
    );

    // behavioural reference, updated on every edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) owner[i] = 0;
        end else begin
            for (int i = 0; i < N; i++) begin
                bit hc, hg, cc, cg;
                hc = host_wr && host_wdata[N+i] &&  host_wdata[i];
                hg = host_wr && host_wdata[N+i] && !host_wdata[i];
                cc = cop_wr  && cop_wdata[N+i]  &&  cop_wdata[i];
                cg = cop_wr  && cop_wdata[N+i]  && !cop_wdata[i];
                if (owner[i] == 0) begin
                    if (hc) owner[i] = 1;
                    else if (cc) owner[i] = 2;
                end else if (owner[i] == 1) begin
                    if (hg) owner[i] = 0;
                end else begin
                    if (cg) owner[i] = 0;
                end
            end
        end
    end

    function automatic logic [W-1:0] exp_word(int who);
        logic [W-1:0] v = '0;
        for (int i = 0; i < N; i++) v[i] = (owner[i] == who);
        return v;
    endfunction

    task automatic compare_now();
        checks++;
        if (host_rdata !== exp_word(1) || cop_rdata !== exp_word(2)) begin
            errors++;
            $display("FAIL %s (R10): host %h cop %h expected host %h cop %h",
                     tag, host_rdata, cop_rdata, exp_word(1), exp_word(2));
        end
        checks++;
        if (host_rdata[W-1:N] !== '0 || cop_rdata[W-1:N] !== '0) begin
            errors++;
            $display("FAIL R2: upper host %h cop %h expected 00 00",
                     host_rdata[W-1:N], cop_rdata[W-1:N]);
        end
        checks++;
        if ((host_rdata[N-1:0] & cop_rdata[N-1:0]) !== '0) begin
            errors++;
            $display("FAIL R9: overlap %h expected 00", host_rdata[N-1:0] & cop_rdata[N-1:0]);
        end
    endtask

    // compare every cycle, away from the active edge
    always @(negedge clk) if (rst_n && !done) compare_now();

    task automatic drive(input logic hw, input logic [W-1:0] hd,
                         input logic cw, input logic [W-1:0] cd, input string t);
        @(posedge clk);
        #1;
        tag = t;
        host_wr = hw; host_wdata = hd;
        cop_wr = cw;  cop_wdata = cd;
    endtask

    task automatic expect_bits(input logic [W-1:0] eh, input logic [W-1:0] ec, input string t);
        @(negedge clk);
        checks++;
        if (host_rdata !== eh || cop_rdata !== ec) begin
            errors++;
            $display("FAIL %s: host %h cop %h expected host %h cop %h",
                     t, host_rdata, cop_rdata, eh, ec);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        expect_bits('0, '0, "R1");
        // R4: host claims bit 0
        drive(1, 16'h0101, 0, '0, "R4");
        drive(0, '0, 0, '0, "R10");
        expect_bits(16'h0001, 16'h0000, "R4");
        // R5: coprocessor claim on host-held bit fails
        drive(0, '0, 1, 16'h0101, "R5");
        drive(0, '0, 0, '0, "R5");
        expect_bits(16'h0001, 16'h0000, "R5");
        // R7: coprocessor release of host-held bit ignored
        drive(0, '0, 1, 16'h0100, "R7");
        drive(0, '0, 0, '0, "R7");
        expect_bits(16'h0001, 16'h0000, "R7");
        // R3: values without enables change nothing
        drive(1, 16'h00FE, 1, 16'h00FF, "R3");
        drive(0, '0, 0, '0, "R3");
        expect_bits(16'h0001, 16'h0000, "R3");
        // R6: owner release
        drive(1, 16'h0100, 0, '0, "R6");
        drive(0, '0, 0, '0, "R6");
        expect_bits(16'h0000, 16'h0000, "R6");
        // R8: simultaneous claim, host wins
        drive(1, 16'h0202, 1, 16'h0202, "R8");
        drive(0, '0, 0, '0, "R8");
        expect_bits(16'h0002, 16'h0000, "R8");
        // R4 and R5 in wide writes
        drive(0, '0, 1, 16'hF0F0, "R4");
        drive(1, 16'hFFFF, 0, '0, "R5");
        drive(0, '0, 0, '0, "R9");
        expect_bits(16'h000F, 16'h00F0, "R9");
        // host release on coprocessor-held bits while coprocessor claims others
        drive(1, 16'hF000, 1, 16'h0F0F, "R7");
        drive(0, '0, 0, '0, "R7");
        expect_bits(16'h000F, 16'h00F0, "R7");
        // coprocessor release of its own bits while host claims them in the same cycle
        drive(1, 16'h3030, 1, 16'h3000, "R6");
        drive(0, '0, 0, '0, "R6");
        expect_bits(16'h000F, 16'h00C0, "R6");
        drive(1, 16'h3030, 0, '0, "R4");
        drive(0, '0, 0, '0, "R4");
        expect_bits(16'h003F, 16'h00C0, "R4");
        // random collisions
        for (int k = 0; k < 2000; k++) begin
            logic [31:0] r1, r2;
            r1 = $urandom; r2 = $urandom;
            drive(r1[16], r1[15:0], r2[16], r2[15:0], "R9");
        end
        drive(0, '0, 0, '0, "R9");
        @(negedge clk);
        // reset returns all to free
        #1 rst_n = 1'b0;
        @(posedge clk);
        #1 rst_n = 1'b1;
        expect_bits('0, '0, "R1");
        finish_run();
    end
endmodule